// File: doc/BRIEF.md
# Four-Level Load-Scaling Operating Point Controller

This block holds one operating point for each of four CPU load levels. Each operating point has four fields: a clock divider, a clock-source select, a PLL select and a supply-voltage select. Firmware programs the operating points and the active level over a simple 32-bit register bus. Every write is a full-word write, and reads are combinational.

A dynamic-mode register controls the block. Its master enable turns scaling on, and four field enables choose which outputs follow the active level. While scaling is on, the outputs carry the fields of the level chosen by the load register. While scaling is off, the outputs carry level 0, the highest-performance level. Scaling also locks the operating-point registers and the load register. Firmware that restores saved state must therefore write the dynamic-mode register last.

Top module: `dvfs_lvl_ctrl`

## Requirements
- R1: After reset, every register reads zero, `cpu_level` is 0, `scaling_on` is 0 and `cpu_div` is 1.
- R2: Offset 0x18 holds levels 0 and 1, and offset 0x1C holds levels 2 and 3. The even level sits in bits 31:16 and the odd level in bits 15:0. Within a half-word, the divider is bits 15:13, the clock-source select is bit 11, the PLL select is bits 10:9 and the voltage select is bits 7:6. All other bits read zero, so a readback equals the written word AND 0xEEC0EEC0.
- R3: Offset 0x30 holds the active load level in bits 1:0. All other bits read zero.
- R4: Offset 0x24 is the dynamic-mode register. Its bits are: clock-select enable at bit 26, PLL enable at bit 28, divider enable at bit 29, voltage enable at bit 30 and master enable at bit 31. A readback equals the written word AND 0xF4000000. A write to this register is always accepted.
- R5: Reads at any other offset return zero. Writes there change no register and no output.
- R6: While the master enable is set, writes to 0x18, 0x1C and 0x30 are ignored.
- R7: A write that clears the master enable takes effect at once. A write to a level register in the next cycle is accepted.
- R8: With the master enable clear, `cpu_div`, `cpu_clk_src`, `cpu_pll_sel` and `cpu_vdd_sel` carry level 0's fields, whatever the load register holds.
- R9: With the master enable set, each output field carries the active level's field when its own enable is set, and level 0's field when it is not.
- R10: A divider field of 0 appears on `cpu_div` as 1. `cpu_div` is never 0.
- R11: `scaling_on` mirrors the master enable. `cpu_level` equals the load register while scaling is on, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Full-word write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cpu_div | output | 3 | Effective clock divider (1..7) |
| cpu_clk_src | output | 1 | Clock-source select (1 = PLL source) |
| cpu_pll_sel | output | 2 | PLL select |
| cpu_vdd_sel | output | 2 | Supply-voltage select |
| cpu_level | output | 2 | Level in force |
| scaling_on | output | 1 | Master enable state |

## Verification
The assertions assume three things about the bus. The write strobe and the address are settled at each rising edge. Reads are taken combinationally from the address currently presented. Reset is held low before the first edge.

The bench keeps to these assumptions by changing the bus only on falling edges and by checking one cycle after each write. It follows the restore order that firmware must use: it clears the master enable before it reprograms any level or load value. It sets the master enable last.

// File: rtl/dvfs_lvl_pkg.sv
package dvfs_lvl_pkg;
   // one operating point
   typedef struct packed {
      logic [2:0] div;
      logic       clk_src;
      logic [1:0] pll;
      logic [1:0] vdd;
   } lvl_cfg_t;

   typedef struct packed {
      logic master;
      logic vdd_en;
      logic div_en;
      logic pll_en;
      logic csel_en;
   } dyn_ctl_t;

   localparam logic [31:0] OFS_PAIR_BASE = 32'h18;
   localparam logic [31:0] OFS_DYN       = 32'h24;
   localparam logic [31:0] OFS_LOAD      = 32'h30;

   // half-word field positions
   localparam int HW_DIV_LSB  = 13;
   localparam int HW_CSEL_BIT = 11;
   localparam int HW_PLL_LSB  = 9;
   localparam int HW_VDD_LSB  = 6;
   localparam int HW_EVEN_SHIFT = 16;

   // dynamic-mode bit positions
   localparam int DYN_CSEL_BIT   = 26;
   localparam int DYN_PLL_BIT    = 28;
   localparam int DYN_DIV_BIT    = 29;
   localparam int DYN_VDD_BIT    = 30;
   localparam int DYN_MASTER_BIT = 31;

   function automatic logic [15:0] cfg_to_half(input lvl_cfg_t c);
      logic [15:0] h;
      h = '0;
      h[HW_DIV_LSB +: 3] = c.div;
      h[HW_CSEL_BIT]     = c.clk_src;
      h[HW_PLL_LSB +: 2] = c.pll;
      h[HW_VDD_LSB +: 2] = c.vdd;
      return h;
   endfunction
endpackage

// File: rtl/dvfs_regfile.sv
module dvfs_regfile
   import dvfs_lvl_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NUM_LVL = 4,
   localparam int LVL_W  = $clog2(NUM_LVL),
   localparam int NUM_PAIR = NUM_LVL / 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       wr,
   input  logic [31:0]                wdata,
   output logic [31:0]                rdata,
   output lvl_cfg_t [NUM_LVL-1:0]     cfg_o,
   output logic [LVL_W-1:0]           load_o,
   output dyn_ctl_t                   dyn_o
);
   lvl_cfg_t [NUM_LVL-1:0] cfg_q;
   logic [LVL_W-1:0]       load_q;
   dyn_ctl_t               dyn_q;
   logic                   unlocked;
   logic                   unused_wbits;

   assign unlocked     = ~dyn_q.master;
   assign unused_wbits = ^wdata;

   generate
      for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
         localparam int PAIR = l / 2;
         localparam int BASE = (l % 2 == 0) ? HW_EVEN_SHIFT : 0;
         localparam logic [31:0] OFS = OFS_PAIR_BASE + 32'(4 * PAIR);
         logic hit;
         assign hit = wr && unlocked && (addr == ADDR_W'(OFS));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cfg_q[l] <= '0;
            end else if (hit) begin
               cfg_q[l].div     <= wdata[BASE+HW_DIV_LSB +: 3];
               cfg_q[l].clk_src <= wdata[BASE+HW_CSEL_BIT];
               cfg_q[l].pll     <= wdata[BASE+HW_PLL_LSB +: 2];
               cfg_q[l].vdd     <= wdata[BASE+HW_VDD_LSB +: 2];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
         dyn_q  <= '0;
      end else if (wr) begin
         if (unlocked && addr == ADDR_W'(OFS_LOAD))
            load_q <= wdata[LVL_W-1:0];
         if (addr == ADDR_W'(OFS_DYN)) begin
            dyn_q.master  <= wdata[DYN_MASTER_BIT];
            dyn_q.vdd_en  <= wdata[DYN_VDD_BIT];
            dyn_q.div_en  <= wdata[DYN_DIV_BIT];
            dyn_q.pll_en  <= wdata[DYN_PLL_BIT];
            dyn_q.csel_en <= wdata[DYN_CSEL_BIT];
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int p = 0; p < NUM_PAIR; p++) begin
         if (addr == ADDR_W'(OFS_PAIR_BASE + 32'(4 * p)))
            rdata = {cfg_to_half(cfg_q[2*p]), cfg_to_half(cfg_q[2*p+1])};
      end
      if (addr == ADDR_W'(OFS_LOAD))
         rdata[LVL_W-1:0] = load_q;
      if (addr == ADDR_W'(OFS_DYN)) begin
         rdata[DYN_MASTER_BIT] = dyn_q.master;
         rdata[DYN_VDD_BIT]    = dyn_q.vdd_en;
         rdata[DYN_DIV_BIT]    = dyn_q.div_en;
         rdata[DYN_PLL_BIT]    = dyn_q.pll_en;
         rdata[DYN_CSEL_BIT]   = dyn_q.csel_en;
      end
   end

   assign cfg_o  = cfg_q;
   assign load_o = load_q;
   assign dyn_o  = dyn_q;
endmodule

// File: rtl/dvfs_lvl_mux.sv
module dvfs_lvl_mux
   import dvfs_lvl_pkg::*;
#(
   parameter int NUM_LVL = 4,
   localparam int LVL_W  = $clog2(NUM_LVL)
) (
   input  lvl_cfg_t [NUM_LVL-1:0] cfg,
   input  logic [LVL_W-1:0]       load,
   input  dyn_ctl_t               dyn,
   output logic [2:0]             div,
   output logic                   clk_src,
   output logic [1:0]             pll,
   output logic [1:0]             vdd,
   output logic [LVL_W-1:0]       level
);
   lvl_cfg_t   act, base;
   logic [2:0] div_raw;

   assign act  = cfg[load];
   assign base = cfg[0];

   assign div_raw = (dyn.master && dyn.div_en)  ? act.div     : base.div;
   assign clk_src = (dyn.master && dyn.csel_en) ? act.clk_src : base.clk_src;
   assign pll     = (dyn.master && dyn.pll_en)  ? act.pll     : base.pll;
   assign vdd     = (dyn.master && dyn.vdd_en)  ? act.vdd     : base.vdd;
   assign div     = (div_raw == 3'd0) ? 3'd1 : div_raw;
   assign level   = dyn.master ? load : '0;
endmodule

// File: rtl/dvfs_lvl_ctrl.sv
module dvfs_lvl_ctrl
   import dvfs_lvl_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NUM_LVL = 4,
   localparam int LVL_W  = $clog2(NUM_LVL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [2:0]        cpu_div,
   output logic              cpu_clk_src,
   output logic [1:0]        cpu_pll_sel,
   output logic [1:0]        cpu_vdd_sel,
   output logic [LVL_W-1:0]  cpu_level,
   output logic              scaling_on
);
   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must reach offset 0x30");
      end
      if (NUM_LVL != 2 && NUM_LVL != 4) begin : g_bad_lvl
         $error("NUM_LVL must be 2 or 4");
      end
   endgenerate

   lvl_cfg_t [NUM_LVL-1:0] cfg_q;
   logic [LVL_W-1:0]       load_q;
   dyn_ctl_t               dyn_q;
   logic                   master_q;

   dvfs_regfile #(.ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .cfg_o(cfg_q), .load_o(load_q), .dyn_o(dyn_q)
   );

   dvfs_lvl_mux #(.NUM_LVL(NUM_LVL)) u_mux (
      .cfg(cfg_q), .load(load_q), .dyn(dyn_q),
      .div(cpu_div), .clk_src(cpu_clk_src), .pll(cpu_pll_sel),
      .vdd(cpu_vdd_sel), .level(cpu_level)
   );

   assign master_q   = dyn_q.master;
   assign scaling_on = master_q;
endmodule

// File: rtl/dvfs_lvl_ctrl_chk.sv
module dvfs_lvl_ctrl_chk #(
   parameter int ADDR_W  = 8,
   parameter int NUM_LVL = 4,
   localparam int LVL_W  = $clog2(NUM_LVL)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [31:0]        reg_rdata,
   input logic [2:0]         cpu_div,
   input logic [LVL_W-1:0]   cpu_level,
   input logic               master_q,
   input logic [LVL_W-1:0]   load_q,
   input logic [NUM_LVL*8-1:0] cfg_flat
);
   logic known_ofs;
   always_comb begin
      known_ofs = (reg_addr == ADDR_W'(8'h24)) || (reg_addr == ADDR_W'(8'h30));
      for (int p = 0; p < NUM_LVL / 2; p++)
         if (reg_addr == ADDR_W'(8'h18 + 4 * p)) known_ofs = 1'b1;
   end

   // R6: locked registers hold while scaling is on
   p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      master_q |=> ($stable(load_q) && $stable(cfg_flat)));

   // R10: divider output never zero
   p_div_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_div != 3'd0);

   // R11: level output is zero when scaling is off
   p_idle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !master_q |-> cpu_level == '0);

   // R11: level output follows the load register when scaling is on
   p_active_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
      master_q |-> cpu_level == load_q);

   // R5: unmapped offsets read zero
   p_undef_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !known_ofs |-> reg_rdata == 32'd0);
endmodule

bind dvfs_lvl_ctrl dvfs_lvl_ctrl_chk #(.ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
   .cpu_div(cpu_div), .cpu_level(cpu_level), .master_q(master_q),
   .load_q(load_q), .cfg_flat(cfg_q)
);

// File: tb/dvfs_lvl_ctrl_tb.sv
`timescale 1ns/1ps
module dvfs_lvl_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  cpu_div;
   logic        cpu_clk_src;
   logic [1:0]  cpu_pll_sel, cpu_vdd_sel, cpu_level;
   logic        scaling_on;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] pair_w [2];   // last accepted writes to the pair registers
   logic [1:0]  load_m;

   always #2.5 clk = ~clk;

   dvfs_lvl_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_div(cpu_div),
      .cpu_clk_src(cpu_clk_src), .cpu_pll_sel(cpu_pll_sel),
      .cpu_vdd_sel(cpu_vdd_sel), .cpu_level(cpu_level), .scaling_on(scaling_on)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
      reg_addr = a;
      #0.5;
      check(req, reg_rdata, exp);
   endtask

   // bench's own field decode of level l from the written words
   function automatic logic [15:0] half_of(input int l);
      logic [31:0] w;
      w = pair_w[l / 2];
      return (l % 2 == 0) ? w[31:16] : w[15:0];
   endfunction

   task automatic check_outputs(input string req, input logic [3:0] en, input logic m);
      logic [15:0] h0, ha, hd, hc, hp, hv;
      logic [2:0]  ed;
      h0 = half_of(0);
      ha = half_of(int'(load_m));
      hd = (m && en[2]) ? ha : h0;
      hc = (m && en[0]) ? ha : h0;
      hp = (m && en[1]) ? ha : h0;
      hv = (m && en[3]) ? ha : h0;
      ed = (hd[15:13] == 3'd0) ? 3'd1 : hd[15:13];
      check({req, " div"}, 32'(cpu_div), 32'(ed));
      check({req, " csel"}, 32'(cpu_clk_src), 32'(hc[11]));
      check({req, " pll"}, 32'(cpu_pll_sel), 32'(hp[10:9]));
      check({req, " vdd"}, 32'(cpu_vdd_sel), 32'(hv[7:6]));
      check("R11 level", 32'(cpu_level), m ? 32'(load_m) : 32'd0);
      check("R11 on", 32'(scaling_on), 32'(m));
   endtask

   // dynamic-mode word from enables {vdd,div,pll,csel}
   function automatic logic [31:0] dyn_word(input logic m, input logic [3:0] en);
      return (32'(m) << 31) | (32'(en[3]) << 30) | (32'(en[2]) << 29)
           | (32'(en[1]) << 28) | (32'(en[0]) << 26);
   endfunction

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      pair_w[0] = '0; pair_w[1] = '0; load_m = '0;
      #12 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd_check("R1 pair01", 8'h18, 32'd0);
      rd_check("R1 pair23", 8'h1C, 32'd0);
      rd_check("R1 dyn", 8'h24, 32'd0);
      rd_check("R1 load", 8'h30, 32'd0);
      check("R1 div", 32'(cpu_div), 32'd1);
      check("R1 level", 32'(cpu_level), 32'd0);
      check("R1 on", 32'(scaling_on), 32'd0);

      // R2 / R3 / R4 readback masks over several patterns
      for (int p = 0; p < 8; p++) begin
         logic [31:0] d;
         d = 32'h9E3779B9 * (p + 1) ^ (32'h0F0F << p);
         wr(8'h18, d);
         rd_check("R2 pair01", 8'h18, d & 32'hEEC0EEC0);
         wr(8'h1C, ~d);
         rd_check("R2 pair23", 8'h1C, ~d & 32'hEEC0EEC0);
         wr(8'h30, d);
         rd_check("R3 load", 8'h30, d & 32'h3);
         wr(8'h24, d & 32'h7FFFFFFF);
         rd_check("R4 dyn", 8'h24, d & 32'h74000000);
         wr(8'h24, 32'd0);
      end

      // distinct per-level configs, level0 divider 0 for R10
      pair_w[0] = {3'd0,1'b0,1'b1,2'd2,1'b0,2'd1,6'd0, 3'd3,1'b0,1'b0,2'd1,1'b0,2'd2,6'd0};
      pair_w[1] = {3'd5,1'b0,1'b1,2'd3,1'b0,2'd3,6'd0, 3'd7,1'b0,1'b0,2'd0,1'b0,2'd0,6'd0};
      wr(8'h18, pair_w[0]);
      wr(8'h1C, pair_w[1]);

      // R8: master clear, any load -> level 0 fields (div 0 -> 1, R10)
      for (int ld = 0; ld < 4; ld++) begin
         load_m = 2'(ld);
         wr(8'h30, 32'(ld));
         wr(8'h24, dyn_word(1'b0, 4'hF));
         check_outputs("R8 R10 idle", 4'hF, 1'b0);
         wr(8'h24, 32'd0);
      end

      // R9: sweep all field-enable subsets and loads with master set
      for (int ld = 0; ld < 4; ld++) begin
         for (int en = 0; en < 16; en++) begin
            wr(8'h24, 32'd0);
            load_m = 2'(ld);
            wr(8'h30, 32'(ld));
            wr(8'h24, dyn_word(1'b1, 4'(en)));
            check_outputs("R9 active", 4'(en), 1'b1);
         end
      end

      // R6: locked writes ignored
      wr(8'h18, 32'hFFFFFFFF);
      rd_check("R6 pair01", 8'h18, pair_w[0]);
      wr(8'h1C, 32'h00000000);
      rd_check("R6 pair23", 8'h1C, pair_w[1]);
      wr(8'h30, 32'(load_m + 2'd1));
      rd_check("R6 load", 8'h30, 32'(load_m));
      check_outputs("R6 outputs", 4'hF, 1'b1);

      // R5: unmapped offset
      wr(8'h20, 32'hFFFFFFFF);
      rd_check("R5 read 0x20", 8'h20, 32'd0);
      rd_check("R5 read 0x14", 8'h14, 32'd0);
      rd_check("R5 dyn intact", 8'h24, 32'hF4000000);
      check_outputs("R5 outputs", 4'hF, 1'b1);

      // R7: clear master then write level register next cycle
      @(negedge clk);
      reg_addr = 8'h24; reg_wdata = 32'd0; reg_wr = 1'b1;
      @(negedge clk);
      reg_addr = 8'h18; reg_wdata = 32'h2A40C6C0;
      @(negedge clk);
      reg_wr = 1'b0;
      pair_w[0] = 32'h2A40C6C0;
      rd_check("R7 accept", 8'h18, 32'h2A40C6C0 & 32'hEEC0EEC0);
      check_outputs("R7 idle", 4'h0, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule